// File: doc/BRIEF.md
# Four-Digit Packed Decimal Adder

This block adds two unsigned decimal numbers held in packed BCD form, four digits to an operand by default, together with a single carry-in bit. It produces a packed BCD sum of the same width and a decimal carry-out. There are no registers in the block. The surrounding logic places its own pipeline stages before or after it as timing requires.

Each digit goes through the same two steps. First the two digits and the incoming carry are added as plain 4-bit binary numbers. Then a small logic term inspects that raw result. The term is true when the raw carry bit is set, or when the top raw bit is set together with either of the two bits below it. When the term is true, six is added to the raw 4-bit value, and the digit passes a carry to the next higher digit.

Only valid decimal digits (0 to 9) are defined as inputs. For digit codes 10 to 15 the output is not specified. Signed and subtracting operation is not provided.

Top module: `bcd_add_chain`

## Requirements
- R1: Digit k of every operand and of the sum occupies bits [4k+3:4k]. The least significant digit sits in bits [3:0].
- R2: When a digit's raw binary sum (both digits plus incoming carry) is 9 or less, the sum digit equals that raw value and no carry goes to the next digit.
- R3: When a digit's raw binary sum is 10 to 19, the sum digit equals the raw value plus six, taken modulo 16, and a carry of one goes to the next digit.
- R4: The correction term is true when the raw carry bit is set, or when raw bit 3 is set together with raw bit 2 or raw bit 1. Raw sums of 16 to 19 are therefore corrected through the raw carry alone (for example 9 + 9 gives digit 8 with a carry).
- R5: Adding 6 and 7 in one digit with no incoming carry gives digit 3 and a carry of one into the next digit.
- R6: The external carry-in enters the raw addition of the least significant digit only. With both operands zero, the sum equals the carry-in.
- R7: Each digit's decimal carry is the carry-in of the next higher digit, so a carry ripples through a run of nines (9999 + 0001 gives 0000 with carry-out 1).
- R8: The decimal carry of the top digit drives the carry-out port. For valid inputs, value(sum) + 10000 * carry-out equals value(a) + value(b) + carry-in.
- R9: All-zero operands with carry-in 0 give an all-zero sum and carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4*NUM_DIGITS (16) | First packed BCD operand |
| opb_i | input | 4*NUM_DIGITS (16) | Second packed BCD operand |
| carry_i | input | 1 | Carry into the least significant digit |
| sum_o | output | 4*NUM_DIGITS (16) | Packed BCD sum |
| carry_o | output | 1 | Decimal carry out of the most significant digit |

## Verification
The least significant digit is driven through all hundred digit pairs, each with carry-in clear and set. This places every raw sum from 0 to 19 on both sides of the correction threshold, and it keeps the cases corrected through the raw carry bit apart from those corrected through the upper-bit term. Directed multi-digit vectors use runs of nines and mixed corrected and uncorrected digits. They show that carries move from digit to digit and that the top carry reaches the output. Random four-digit operands, compared against a decimal reference, cover interactions that the directed cases miss.

// File: rtl/bcd_add_pkg.sv
// Package bcd_add_pkg
// Shared digit width, digit type and correction constant for the packed
// decimal adder. Assumes 4-bit binary coded decimal digits.
package bcd_add_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;
    // Offset that moves a binary digit sum above nine back into range.
    localparam digit_t CORR_VAL = digit_t'(6);
endpackage

// File: rtl/bcd_nibble_add.sv
// Module bcd_nibble_add
// Plain binary addition of two digits and a carry. Produces a raw 4-bit
// sum and the raw carry bit. Does no decimal interpretation.
module bcd_nibble_add
    import bcd_add_pkg::*;
(
    input  digit_t a_dig,
    input  digit_t b_dig,
    input  logic   c_in,
    output digit_t raw_sum,
    output logic   raw_carry
);
    // Widen to DIGIT_W+1 bits so the raw carry is kept.
    always_comb begin
        {raw_carry, raw_sum} = {1'b0, a_dig} + {1'b0, b_dig} + {{DIGIT_W{1'b0}}, c_in};
    end
endmodule

// File: rtl/bcd_carry_detect.sv
// Module bcd_carry_detect
// Decides from the raw digit sum whether it exceeds nine. Uses a fixed logic
// term, not a magnitude compare. Assumes a 4-bit raw sum plus raw carry.
module bcd_carry_detect
    import bcd_add_pkg::*;
(
    input  digit_t raw_sum,
    input  logic   raw_carry,
    output logic   fix_need
);
    // Above nine: raw carry set, or 8s bit with either the 4s or 2s bit.
    always_comb begin
        fix_need = raw_carry | (raw_sum[3] & (raw_sum[2] | raw_sum[1]));
    end
endmodule

// File: rtl/bcd_digit_correct.sv
// Module bcd_digit_correct
// Adds the correction offset to the raw digit when asked and drops the bits
// above the digit width. Assumes fix_need comes from bcd_carry_detect.
module bcd_digit_correct
    import bcd_add_pkg::*;
(
    input  digit_t raw_sum,
    input  logic   fix_need,
    output digit_t dec_sum
);
    // Select the corrected or the untouched raw value.
    always_comb begin
        dec_sum = fix_need ? digit_t'(raw_sum + CORR_VAL) : raw_sum;
    end
endmodule

// File: rtl/bcd_digit_cell.sv
// Module bcd_digit_cell
// One decimal digit position: raw add, excess detection, correction. The
// decimal carry out is the correction flag. Assumes valid input digits.
module bcd_digit_cell
    import bcd_add_pkg::*;
(
    input  digit_t a_dig,
    input  digit_t b_dig,
    input  logic   c_in,
    output digit_t s_dig,
    output logic   c_out
);
    digit_t raw_sum;
    logic   raw_carry;
    logic   fix_need;

    bcd_nibble_add u_add (
        .a_dig     (a_dig),
        .b_dig     (b_dig),
        .c_in      (c_in),
        .raw_sum   (raw_sum),
        .raw_carry (raw_carry)
    );

    bcd_carry_detect u_det (
        .raw_sum   (raw_sum),
        .raw_carry (raw_carry),
        .fix_need  (fix_need)
    );

    bcd_digit_correct u_cor (
        .raw_sum  (raw_sum),
        .fix_need (fix_need),
        .dec_sum  (s_dig)
    );

    // The decimal carry is exactly the correction decision.
    always_comb begin
        c_out = fix_need;
    end
endmodule

// File: rtl/bcd_add_chain.sv
// Module bcd_add_chain
// Packed decimal adder of NUM_DIGITS digits, with the least significant digit
// in bits [3:0]. Digit cells are chained through their decimal carries.
// Purely combinational. Output is undefined for digit codes above nine.
module bcd_add_chain
    import bcd_add_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic [DIGIT_W*NUM_DIGITS-1:0] opa_i,
    input  logic [DIGIT_W*NUM_DIGITS-1:0] opb_i,
    input  logic                          carry_i,
    output logic [DIGIT_W*NUM_DIGITS-1:0] sum_o,
    output logic                          carry_o
);
    localparam int TOTAL_W = DIGIT_W * NUM_DIGITS;

    logic [NUM_DIGITS:0] dcarry;

    // External carry feeds the lowest digit; the top digit's carry leaves.
    always_comb begin
        dcarry[0] = carry_i;
        carry_o   = dcarry[NUM_DIGITS];
    end

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        bcd_digit_cell u_cell (
            .a_dig (opa_i[k*DIGIT_W +: DIGIT_W]),
            .b_dig (opb_i[k*DIGIT_W +: DIGIT_W]),
            .c_in  (dcarry[k]),
            .s_dig (sum_o[k*DIGIT_W +: DIGIT_W]),
            .c_out (dcarry[k+1])
        );
    end

    if (TOTAL_W < DIGIT_W) begin : g_bad_cfg
        initial $error("NUM_DIGITS must be at least one");
    end
endmodule

// File: rtl/bcd_add_chain_chk.sv
// Module bcd_add_chain_chk
// Assertion checker for bcd_add_chain. It sees only the ports and judges them
// against decimal arithmetic. Checks apply only when every input digit is valid.
module bcd_add_chain_chk
    import bcd_add_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input logic [DIGIT_W*NUM_DIGITS-1:0] opa_i,
    input logic [DIGIT_W*NUM_DIGITS-1:0] opb_i,
    input logic                          carry_i,
    input logic [DIGIT_W*NUM_DIGITS-1:0] sum_o,
    input logic                          carry_o
);
    localparam int TOTAL_W = DIGIT_W * NUM_DIGITS;

    function automatic logic all_legal(input logic [TOTAL_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (v[k*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic longint dec_val(input logic [TOTAL_W-1:0] v);
        longint acc;
        acc = 0;
        for (int k = NUM_DIGITS - 1; k >= 0; k--) begin
            acc = acc * 10 + longint'(v[k*DIGIT_W +: DIGIT_W]);
        end
        return acc;
    endfunction

    function automatic longint full_scale();
        longint s;
        s = 1;
        for (int k = 0; k < NUM_DIGITS; k++) s = s * 10;
        return s;
    endfunction

    logic   in_ok;
    longint want;
    int     lsd_raw;

    always_comb begin
        in_ok   = all_legal(opa_i) && all_legal(opb_i);
        want    = dec_val(opa_i) + dec_val(opb_i) + longint'(carry_i);
        lsd_raw = int'(opa_i[3:0]) + int'(opb_i[3:0]) + int'(carry_i);
        if (in_ok) begin
            AST_DEC_IDENTITY: assert (dec_val(sum_o) + (carry_o ? full_scale() : 0) == want); // R8
            AST_CARRY_THRESHOLD: assert (carry_o == (want >= full_scale())); // R8
            AST_SUM_LEGAL: assert (all_legal(sum_o)); // R3
            AST_ZERO_PASS: assert (!(opa_i == '0 && opb_i == '0) || (sum_o == TOTAL_W'(carry_i) && !carry_o)); // R6
            if (lsd_raw <= 9) begin
                AST_LSD_PLAIN: assert (int'(sum_o[3:0]) == lsd_raw); // R2
            end else begin
                AST_LSD_CORRECTED: assert (int'(sum_o[3:0]) == lsd_raw - 10); // R3
            end
        end
    end
endmodule

bind bcd_add_chain bcd_add_chain_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .carry_i (carry_i),
    .sum_o   (sum_o),
    .carry_o (carry_o)
);

// File: tb/sim_bcd_add_chain.sv
// Bench for bcd_add_chain. Walks a vector table, sweeps every single-digit
// pair with both carry-in values, then random four-digit operands, all checked
// against a decimal reference computed here.
module sim_bcd_add_chain;
    localparam int CLK_PERIOD = 10;
    localparam int ND         = 4;
    localparam int W          = 4 * ND;
    localparam int WATCHDOG   = 20000;
    localparam int N_VEC      = 10;
    localparam int N_RAND     = 300;

    // Vector fields: {opa, opb, carry_in, expected sum, expected carry_out}
    localparam logic [49:0] VEC [N_VEC] = '{
        {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},  // R9 all zero
        {16'h0006, 16'h0007, 1'b0, 16'h0013, 1'b0},  // R5 six plus seven
        {16'h9999, 16'h0001, 1'b0, 16'h0000, 1'b1},  // R7 ripple through nines
        {16'h9999, 16'h9999, 1'b1, 16'h9999, 1'b1},  // R8 largest sum
        {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},  // R6 carry-in alone
        {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},  // R2 no correction
        {16'h0009, 16'h0009, 1'b0, 16'h0018, 1'b0},  // R4 raw carry path
        {16'h0908, 16'h0802, 1'b0, 16'h1710, 1'b0},  // R3 mixed digits
        {16'h5000, 16'h5000, 1'b0, 16'h0000, 1'b1},  // R8 top digit carry
        {16'h0099, 16'h0001, 1'b1, 16'h0101, 1'b0}   // R7 two-digit ripple
    };

    logic         clk;
    logic         rst_n;
    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout;

    int n_run;
    int n_fail;

    bcd_add_chain #(.NUM_DIGITS(ND)) u0 (
        .opa_i   (opa),
        .opb_i   (opb),
        .carry_i (cin),
        .sum_o   (sum),
        .carry_o (cout)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int t;
        t = v;
        r = '0;
        for (int k = 0; k < ND; k++) begin
            r[k*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // Drive after a rising edge, sample at the following falling edge.
    task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                               input logic [W-1:0] exp_s, input logic exp_c, input string tag);
        @(posedge clk);
        opa = a;
        opb = b;
        cin = c;
        @(negedge clk);
        n_run++;
        if (sum !== exp_s || cout !== exp_c) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%0b got sum=%h cout=%0b expected sum=%h cout=%0b",
                     tag, a, b, c, sum, cout, exp_s, exp_c);
        end
    endtask

    initial begin
        int total;
        n_run  = 0;
        n_fail = 0;
        rst_n  = 1'b0;
        opa    = '0;
        opb    = '0;
        cin    = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R9: quiet state at start
        apply_check('0, '0, 1'b0, '0, 1'b0, "R9");

        // Table walk covering R2..R9
        for (int i = 0; i < N_VEC; i++) begin
            apply_check(VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:1], VEC[i][0], "R8_table");
        end

        // R1 R2 R3 R4 R6: every digit pair in the lowest digit, both carry-ins
        for (int c = 0; c < 2; c++) begin
            for (int x = 0; x < 10; x++) begin
                for (int y = 0; y < 10; y++) begin
                    total = x + y + c;
                    apply_check(to_bcd(x), to_bcd(y), c[0], to_bcd(total), 1'b0,
                                (total > 9) ? "R3" : "R2");
                end
            end
        end

        // R1: a digit pair in the top position must land there
        apply_check(16'h7000, 16'h6000, 1'b0, 16'h3000, 1'b1, "R1");

        // R7 R8: random four-digit operands
        for (int i = 0; i < N_RAND; i++) begin
            int va;
            int vb;
            int vc;
            va    = int'($urandom_range(9999, 0));
            vb    = int'($urandom_range(9999, 0));
            vc    = int'($urandom_range(1, 0));
            total = va + vb + vc;
            apply_check(to_bcd(va), to_bcd(vb), vc[0], to_bcd(total % 10000), total >= 10000, "R8");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule